// File: doc/BRIEF.md
# PC Card Byte-Lane Steering

This block sits between the 16-bit data edge of a memory card and two byte-wide storage devices. One device holds the even bytes and the other holds the odd bytes. It decodes the two active-low card-enable strobes, address bit 0, output enable, write enable and the attribute-space select. From these it chooses one of four modes: standby, byte, word or odd-byte-only.

For reads, the block selects which device byte appears on each host lane. It also raises a separate drive enable per lane, so that an outside tri-state buffer can be modelled. For writes, it raises a strobe for each target device and routes the right host lane to each device's write data.

An 8-bit host reaches every byte through the low lane by toggling address bit 0. In attribute space only even bytes carry meaning. Every odd-byte position there reads as a fixed not-valid pattern, and no write ever reaches the odd side.

Top module: `pccard_lane_steer`

## Requirements
- R1: With both card enables high (standby), neither lane drive enable (1 = driving) and neither write strobe (1 = writing) is asserted, whatever the other inputs are.
- R2: Byte mode is low-enable asserted and high-enable deasserted. A byte-mode read with address bit 0 low drives only the low lane, with the even device's byte; bits 15:8 of the read bus are zero.
- R3: A byte-mode read with address bit 0 high drives only the low lane, with the odd device's byte.
- R4: Word mode is both enables low. A word-mode read drives both lanes: odd byte on bits 15:8 and even byte on bits 7:0, independent of address bit 0.
- R5: Odd-only mode is high-enable low and low-enable high. An odd-only read drives only the high lane with the odd byte; bits 7:0 are zero.
- R6: A lane is driven only while output enable is low and write enable is high. Otherwise both drive enables are 0 and the read bus is all zero.
- R7: In attribute space (attribute select low), every odd-byte position on a driven lane reads as the parameter NOT_VALID (default 8'hFF). Even bytes read normally.
- R8: A byte-mode write strobes only the even device when address bit 0 is low, or only the odd device when it is high. In both cases the data comes from host bits 7:0.
- R9: A word-mode write strobes both devices. The even device takes host bits 7:0 and the odd device takes host bits 15:8.
- R10: An odd-only write strobes only the odd device, with host bits 15:8.
- R11: In attribute space the odd-device strobe is never asserted. Even-byte writes still reach the even device.
- R12: No write strobe is asserted while write enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ce_lo_n | input | 1 | Card enable for the even byte, active low |
| ce_hi_n | input | 1 | Card enable for the odd byte, active low |
| addr0 | input | 1 | Address bit 0, picks the byte in byte mode |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| attr_n | input | 1 | Attribute-space select, active low |
| host_wdata | input | 16 | Write data from the card edge |
| even_rdata | input | 8 | Byte read from the even device |
| odd_rdata | input | 8 | Byte read from the odd device |
| host_rdata | output | 16 | Steered read data toward the card edge |
| drv_lo | output | 1 | Drive enable for bits 7:0 |
| drv_hi | output | 1 | Drive enable for bits 15:8 |
| even_wr | output | 1 | Write strobe for the even device |
| odd_wr | output | 1 | Write strobe for the odd device |
| even_wdata | output | 8 | Data routed to the even device |
| odd_wdata | output | 8 | Data routed to the odd device |

## Verification
The embedded assertions check, on every input change, the rules that hold in all modes:
- standby stays quiet;
- the high lane never drives in byte mode;
- drive and write strobe are never active together;
- strobes need write enable;
- the odd side is never written in attribute space;
- a driven high lane in attribute space always shows the not-valid pattern.

The scenarios are the only way to show which device byte lands on which lane. They also show that address bit 0 swaps the odd byte onto the low lane in byte mode yet has no effect in word mode, and which host lane each device receives on a write.

// File: rtl/pccard_lane_steer.sv
module pccard_lane_steer #(
  parameter int LANE_W = 8,
  parameter logic [LANE_W-1:0] NOT_VALID = '1
) (
  input  logic                  ce_lo_n,
  input  logic                  ce_hi_n,
  input  logic                  addr0,
  input  logic                  oe_n,
  input  logic                  we_n,
  input  logic                  attr_n,
  input  logic [2*LANE_W-1:0]   host_wdata,
  input  logic [LANE_W-1:0]     even_rdata,
  input  logic [LANE_W-1:0]     odd_rdata,
  output logic [2*LANE_W-1:0]   host_rdata,
  output logic                  drv_lo,
  output logic                  drv_hi,
  output logic                  even_wr,
  output logic                  odd_wr,
  output logic [LANE_W-1:0]     even_wdata,
  output logic [LANE_W-1:0]     odd_wdata
);

  localparam int BUS_W = 2 * LANE_W;

  logic mode_byte, mode_word, mode_odd;
  logic rd_cyc, wr_cyc;
  logic even_hit, odd_hit;
  logic [LANE_W-1:0] odd_src, lo_lane;

  assign mode_byte = !ce_lo_n &&  ce_hi_n;
  assign mode_word = !ce_lo_n && !ce_hi_n;
  assign mode_odd  =  ce_lo_n && !ce_hi_n;

  assign rd_cyc = !oe_n && we_n;
  assign wr_cyc = !we_n;

  assign odd_src = attr_n ? odd_rdata : NOT_VALID;
  assign lo_lane = (mode_byte && addr0) ? odd_src : even_rdata;

  assign drv_lo = rd_cyc && (mode_byte || mode_word);
  assign drv_hi = rd_cyc && (mode_word || mode_odd);

  assign host_rdata[LANE_W-1:0]     = drv_lo ? lo_lane : '0;
  assign host_rdata[BUS_W-1:LANE_W] = drv_hi ? odd_src : '0;

  assign even_hit = mode_word || (mode_byte && !addr0);
  assign odd_hit  = mode_word || mode_odd || (mode_byte && addr0);

  assign even_wr = wr_cyc && even_hit;
  assign odd_wr  = wr_cyc && odd_hit && attr_n;

  assign even_wdata = host_wdata[LANE_W-1:0];
  assign odd_wdata  = mode_byte ? host_wdata[LANE_W-1:0] : host_wdata[BUS_W-1:LANE_W];

  always_comb begin
    // R1
    standby_quiet_chk: assert (!(ce_lo_n && ce_hi_n) || !(drv_lo || drv_hi || even_wr || odd_wr));
    // R2
    byte_hi_idle_chk: assert (!(!ce_lo_n && ce_hi_n) || !drv_hi);
    // R6
    drive_vs_strobe_chk: assert (!(even_wr || odd_wr) || !(drv_lo || drv_hi));
    // R12
    strobe_needs_we_chk: assert (!we_n || !(even_wr || odd_wr));
    // R11
    attr_odd_wr_chk: assert (attr_n || !odd_wr);
    // R7
    attr_hi_invalid_chk: assert (attr_n || !drv_hi || host_rdata[BUS_W-1:LANE_W] == NOT_VALID);
  end

endmodule

// File: tb/pccard_lane_steer_bench.sv
module pccard_lane_steer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic ce_lo_n = 1'b1, ce_hi_n = 1'b1, addr0 = 1'b0, oe_n = 1'b1, we_n = 1'b1, attr_n = 1'b1;
  logic [15:0] host_wdata = 16'hBEEF;
  logic [7:0]  even_rdata = 8'hA5, odd_rdata = 8'h3C;
  logic [15:0] host_rdata;
  logic drv_lo, drv_hi, even_wr, odd_wr;
  logic [7:0] even_wdata, odd_wdata;

  pccard_lane_steer u_pccard_lane_steer (
    .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .addr0(addr0), .oe_n(oe_n), .we_n(we_n),
    .attr_n(attr_n), .host_wdata(host_wdata), .even_rdata(even_rdata), .odd_rdata(odd_rdata),
    .host_rdata(host_rdata), .drv_lo(drv_lo), .drv_hi(drv_hi), .even_wr(even_wr),
    .odd_wr(odd_wr), .even_wdata(even_wdata), .odd_wdata(odd_wdata)
  );

  typedef struct packed {
    logic        dlo, dhi;
    logic [15:0] rdata;
    logic        ewr, owr;
    logic [7:0]  ewd, owd;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic step(input logic cl, ch, a, oe, we, at,
                      input logic dlo, dhi, input logic [15:0] rd,
                      input logic ewr, owr, input logic [7:0] ewd, owd,
                      input string tag);
    exp_t e;
    @(posedge clk);
    ce_lo_n = cl; ce_hi_n = ch; addr0 = a; oe_n = oe; we_n = we; attr_n = at;
    e = '{dlo: dlo, dhi: dhi, rdata: rd, ewr: ewr, owr: owr, ewd: ewd, owd: owd};
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      exp_t  act;
      string t;
      bit    bad;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      act = '{dlo: drv_lo, dhi: drv_hi, rdata: host_rdata, ewr: even_wr, owr: odd_wr,
              ewd: even_wdata, owd: odd_wdata};
      bad = (act.dlo !== e.dlo) || (act.dhi !== e.dhi) || (act.rdata !== e.rdata) ||
            (act.ewr !== e.ewr) || (act.owr !== e.owr) ||
            (e.ewr && act.ewd !== e.ewd) || (e.owr && act.owd !== e.owd);
      checks++;
      if (bad) begin
        fails++;
        $display("FAIL %s: actual drv=%b%b rd=%h wr=%b%b wd=%h/%h expected drv=%b%b rd=%h wr=%b%b wd=%h/%h",
                 t, act.dhi, act.dlo, act.rdata, act.ewr, act.owr, act.ewd, act.owd,
                 e.dhi, e.dlo, e.rdata, e.ewr, e.owr, e.ewd, e.owd);
      end
    end
  end

  initial begin
    // cl ch a oe we at | dlo dhi rdata ewr owr ewd owd
    step(1,1,0,0,1,1, 0,0,16'h0000, 0,0,8'h00,8'h00, "R1 standby read");
    step(1,1,1,1,0,0, 0,0,16'h0000, 0,0,8'h00,8'h00, "R1 standby write");
    step(0,1,0,0,1,1, 1,0,16'h00A5, 0,0,8'h00,8'h00, "R2 byte read even");
    step(0,1,1,0,1,1, 1,0,16'h003C, 0,0,8'h00,8'h00, "R3 byte read odd");
    step(0,0,0,0,1,1, 1,1,16'h3CA5, 0,0,8'h00,8'h00, "R4 word read a0=0");
    step(0,0,1,0,1,1, 1,1,16'h3CA5, 0,0,8'h00,8'h00, "R4 word read a0=1");
    step(1,0,0,0,1,1, 0,1,16'h3C00, 0,0,8'h00,8'h00, "R5 odd-only read");
    step(0,1,0,1,1,1, 0,0,16'h0000, 0,0,8'h00,8'h00, "R6 oe high");
    step(0,0,0,0,0,1, 0,0,16'h0000, 1,1,8'hEF,8'hBE, "R6 oe and we low");
    step(0,1,0,0,1,0, 1,0,16'h00A5, 0,0,8'h00,8'h00, "R7 attr byte even");
    step(0,1,1,0,1,0, 1,0,16'h00FF, 0,0,8'h00,8'h00, "R7 attr byte odd");
    step(0,0,0,0,1,0, 1,1,16'hFFA5, 0,0,8'h00,8'h00, "R7 attr word");
    step(1,0,0,0,1,0, 0,1,16'hFF00, 0,0,8'h00,8'h00, "R7 attr odd-only");
    step(0,1,0,1,0,1, 0,0,16'h0000, 1,0,8'hEF,8'h00, "R8 byte write even");
    step(0,1,1,1,0,1, 0,0,16'h0000, 0,1,8'h00,8'hEF, "R8 byte write odd");
    step(0,0,1,1,0,1, 0,0,16'h0000, 1,1,8'hEF,8'hBE, "R9 word write");
    step(1,0,0,1,0,1, 0,0,16'h0000, 0,1,8'h00,8'hBE, "R10 odd-only write");
    step(0,1,1,1,0,0, 0,0,16'h0000, 0,0,8'h00,8'h00, "R11 attr byte write odd");
    step(0,0,0,1,0,0, 0,0,16'h0000, 1,0,8'hEF,8'h00, "R11 attr word write");
    step(1,0,0,1,0,0, 0,0,16'h0000, 0,0,8'h00,8'h00, "R11 attr odd-only write");
    step(0,0,0,1,1,1, 0,0,16'h0000, 0,0,8'h00,8'h00, "R12 we high");
    step(0,1,1,0,1,1, 1,0,16'h003C, 0,0,8'h00,8'h00, "R3 byte read odd again");
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule